// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block makes a pair of slow clock phases from one fast system clock. A divider counts system clocks and gives a one-cycle step pulse. A 2-bit step counter moves forward on each pulse, so one output period is four steps long. In the fixed waveform, the second phase is high in steps 1, 2 and 3. The first phase is high only in step 2. This leaves one full step of guard time before its rise and after its fall.

A build parameter selects which of the four counter encodings drives the decode. All four give the same waveform at the ports. A table mode replaces the fixed decode with two 4-bit patterns, so other four-step sequences can be used. The divide value, the mode and the patterns are captured during reset, and after that only at the step-3 to step-0 boundary. Both phases come from flip-flops. A status flag reports a loaded table in which the first phase would be high while the second is low.

With a system clock of F, a divide value D gives an output frequency of F/(4·D). This reaches a range from about 1 Hz to about 100 kHz from a clock of a few MHz.

Top module: `twophase_clkgen`

## Requirements
- R1: While `rst` is high, the next clock edge drives `ph1` and `ph2` to 0, restarts the sequence at step 0, and captures `div_val`, `tbl_en`, `pat1_in` and `pat2_in` as the active settings.
- R2: Each step lasts exactly max(D,1) system clocks, where D is the active divide value, so one output period is 4·max(D,1) clocks.
- R3: A divide value of 0 behaves like 1: the step advances on every clock.
- R4: With `tbl_en` = 0, `ph2` is 0,1,1,1 and `ph1` is 0,0,1,0 over steps 0 to 3, for every value of the counter-encoding parameter `MAP_SEL` (0 to 3).
- R5: With `tbl_en` = 0, `ph1` is never high while `ph2` is low. `ph2` rises one full step before `ph1` rises and falls one full step after `ph1` falls.
- R6: With `tbl_en` = 1, the level of `ph1` in step s is bit s of the active `pat1_in` value, and the level of `ph2` is bit s of the active `pat2_in` value (bit 0 = step 0).
- R7: Changes on `div_val`, `tbl_en`, `pat1_in` or `pat2_in` have no effect unless they are present on the clock edge where step 3 ends or while reset is active. Those captured values apply from the following step 0.
- R8: Each output is registered. A step's level appears at `ph1`/`ph2` one clock after the counter enters that step, and it holds for the whole step.
- R9: `pat_err` is 1 exactly when the active settings have `tbl_en` = 1 and some bit is set in `pat1_in` but clear in `pat2_in`. It changes only when settings are captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_val | input | DIV_W | System clocks per step (0 behaves as 1) |
| tbl_en | input | 1 | 1 selects the pattern table, 0 the fixed waveform |
| pat1_in | input | 4 | Phase-1 level per step, bit s = step s |
| pat2_in | input | 4 | Phase-2 level per step, bit s = step s |
| ph1 | output | 1 | Registered phase 1 |
| ph2 | output | 1 | Registered phase 2 |
| pat_err | output | 1 | Active table breaks the nesting of phase 1 inside phase 2 |

## Verification
A divider that reloads wrongly changes the step length. This shows up within one period as a phase edge that is off by whole system clocks against the expected schedule. A counter that starts in the wrong encoding or skips a step rotates the waveform. The error appears at the first step after reset. Settings captured at the wrong moment change the edges or `pat_err` before the step-0 boundary. The bench uses a short glitch on the inputs in the middle of a period so that such an error shows up within a few clocks.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef logic [1:0] step_t;

    typedef struct packed {
        logic p1;
        logic p2;
    } phase_t;

    typedef struct packed {
        logic       tbl;
        logic [3:0] p1;
        logic [3:0] p2;
    } wave_cfg_t;

    // Counter code that stands for step 0 under a given encoding
    function automatic step_t map_offset(input int unsigned sel);
        return step_t'(sel[1:0]);
    endfunction

    // Fixed nested waveform decoded straight from the counter code
    function automatic phase_t fixed_decode(input int unsigned sel, input step_t c);
        phase_t r;
        case (sel[1:0])
            2'd0: begin r.p1 = c[1] & ~c[0];    r.p2 = c[1] | c[0];    end
            2'd1: begin r.p1 = c[1] & c[0];     r.p2 = c[1] | ~c[0];   end
            2'd2: begin r.p1 = ~(c[1] | c[0]);  r.p2 = ~c[1] | c[0];   end
            default: begin r.p1 = ~c[1] & c[0]; r.p2 = ~(c[1] & c[0]); end
        endcase
        return r;
    endfunction

    function automatic logic nest_broken(input logic tbl, input logic [3:0] a, input logic [3:0] b);
        return tbl & (|(a & ~b));
    endfunction

endpackage

// File: rtl/tp_prescaler.sv
module tp_prescaler #(
    parameter int unsigned DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] reload_val,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_m1;

    // zero is treated as a divide of one
    assign eff_m1 = (reload_val == '0) ? '0 : reload_val - ONE;
    assign tick   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= eff_m1;
        else             cnt <= cnt - ONE;
    end

    // R2: a divide above one never gives back-to-back ticks
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && eff_m1 != '0) |=> !tick);

    // R3: a zero divide ticks on every clock
    a_r3_zero_div: assert property (@(posedge clk) disable iff (rst)
        (tick && reload_val == '0) |=> tick);

endmodule

// File: rtl/tp_step_ctr.sv
module tp_step_ctr
    import tp_pkg::*;
#(
    parameter step_t OFFSET = 2'd0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output step_t code,
    output step_t slot,
    output logic  at_last
);
    always_ff @(posedge clk) begin
        if (rst)      code <= OFFSET;
        else if (adv) code <= code + step_t'(1);
    end

    assign slot    = code - OFFSET;
    assign at_last = (slot == 2'd3);

    // R1: reset lands on the step-0 code of the chosen encoding
    a_r1_reset_slot: assert property (@(posedge clk)
        rst |=> (slot == 2'd0));

    // R2: one step per tick, none without
    a_r2_step_adv: assert property (@(posedge clk) disable iff (rst)
        adv |=> (code == $past(code) + step_t'(1)));
    a_r2_step_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(code));

endmodule

// File: rtl/tp_phase_out.sv
module tp_phase_out
    import tp_pkg::*;
#(
    parameter int unsigned MAP_SEL = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  step_t     code,
    input  step_t     slot,
    input  wave_cfg_t cfg,
    output phase_t    ph,
    output phase_t    nxt
);
    always_comb begin
        if (cfg.tbl) begin
            nxt.p1 = cfg.p1[slot];
            nxt.p2 = cfg.p2[slot];
        end else begin
            nxt = fixed_decode(MAP_SEL, code);
        end
    end

    // outputs only ever leave a flop
    always_ff @(posedge clk) begin
        if (rst) ph <= '0;
        else     ph <= nxt;
    end

    // R4: fixed waveform keyed to the step index, whatever the encoding
    a_r4_step0_low: assert property (@(posedge clk) disable iff (rst)
        (!cfg.tbl && slot == 2'd0) |-> (!nxt.p1 && !nxt.p2));
    a_r4_step2_high: assert property (@(posedge clk) disable iff (rst)
        (!cfg.tbl && slot == 2'd2) |-> (nxt.p1 && nxt.p2));
    a_r4_guard_steps: assert property (@(posedge clk) disable iff (rst)
        (!cfg.tbl && (slot == 2'd1 || slot == 2'd3)) |-> (!nxt.p1 && nxt.p2));

endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen
    import tp_pkg::*;
#(
    parameter int unsigned DIV_W   = 20,
    parameter int unsigned MAP_SEL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             tbl_en,
    input  logic [3:0]       pat1_in,
    input  logic [3:0]       pat2_in,
    output logic             ph1,
    output logic             ph2,
    output logic             pat_err
);
    localparam step_t START_CODE = map_offset(MAP_SEL);

    logic             tick;
    logic             at_last;
    logic             load;
    step_t            code;
    step_t            slot;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] reload_val;
    wave_cfg_t        cfg_q;
    logic             err_q;
    phase_t           ph_q;
    phase_t           dec;

    // settings are taken in reset and where step 3 ends
    assign load = rst | (tick & at_last);

    always_ff @(posedge clk) begin
        if (load) begin
            div_q     <= div_val;
            cfg_q.tbl <= tbl_en;
            cfg_q.p1  <= pat1_in;
            cfg_q.p2  <= pat2_in;
            err_q     <= nest_broken(tbl_en, pat1_in, pat2_in);
        end
    end

    // a fresh divide applies already to the step-0 that follows the load
    assign reload_val = load ? div_val : div_q;

    tp_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .reload_val (reload_val),
        .tick       (tick)
    );

    tp_step_ctr #(.OFFSET(START_CODE)) u_step (
        .clk     (clk),
        .rst     (rst),
        .adv     (tick),
        .code    (code),
        .slot    (slot),
        .at_last (at_last)
    );

    tp_phase_out #(.MAP_SEL(MAP_SEL)) u_out (
        .clk  (clk),
        .rst  (rst),
        .code (code),
        .slot (slot),
        .cfg  (cfg_q),
        .ph   (ph_q),
        .nxt  (dec)
    );

    assign ph1     = ph_q.p1;
    assign ph2     = ph_q.p2;
    assign pat_err = err_q;

    // R7, R9: active settings and flag move only on a capture
    a_r7_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(div_q) && $stable(cfg_q) && $stable(err_q)));

    // R5: unless flagged, phase 1 is never decoded outside phase 2
    a_r5_nesting: assert property (@(posedge clk) disable iff (rst)
        (!err_q && dec.p1) |-> dec.p2);

endmodule

// File: tb/test_twophase_clkgen.sv
module test_twophase_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 20;
    localparam int NMAP       = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_val = '0;
    logic             tbl_en = 1'b0;
    logic [3:0]       pat1_in = '0;
    logic [3:0]       pat2_in = '0;
    logic [NMAP-1:0]  ph1_w;
    logic [NMAP-1:0]  ph2_w;
    logic [NMAP-1:0]  err_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        twophase_clkgen #(.DIV_W(DIV_W), .MAP_SEL(m)) i_twophase_clkgen (
            .clk     (clk),
            .rst     (rst),
            .div_val (div_val),
            .tbl_en  (tbl_en),
            .pat1_in (pat1_in),
            .pat2_in (pat2_in),
            .ph1     (ph1_w[m]),
            .ph2     (ph2_w[m]),
            .pat_err (err_w[m])
        );
    end

    typedef struct {
        logic  p1;
        logic  p2;
        logic  err;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // reference state: step, clocks into step, captured settings
    logic [1:0] m_slot;
    int         m_sub;
    int         m_div;
    logic       m_tbl;
    logic [3:0] m_p1;
    logic [3:0] m_p2;
    logic       m_err;

    task automatic model_capture();
        m_div = (div_val == '0) ? 1 : int'(div_val);
        m_tbl = tbl_en;
        m_p1  = pat1_in;
        m_p2  = pat2_in;
        m_err = tbl_en & (|(pat1_in & ~pat2_in));
    endtask

    // one clock: expect the level of the current step after the next edge
    task automatic clk_step(input string tag);
        exp_t e;
        e.p1 = m_tbl ? m_p1[m_slot] : (m_slot == 2'd2);
        e.p2 = m_tbl ? m_p2[m_slot] : (m_slot != 2'd0);
        if (m_sub == m_div - 1) begin
            m_sub = 0;
            if (m_slot == 2'd3) begin
                m_slot = 2'd0;
                model_capture();
            end else begin
                m_slot = m_slot + 2'd1;
            end
        end else begin
            m_sub = m_sub + 1;
        end
        e.err = m_err;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic do_reset(input string tag);
        exp_t e;
        rst = 1'b1;
        model_capture();
        m_slot = 2'd0;
        m_sub  = 0;
        e.p1 = 1'b0;
        e.p2 = 1'b0;
        e.err = m_err;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: compare every instance against the queued expectation
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            for (int m = 0; m < NMAP; m++) begin
                total++;
                if ({ph1_w[m], ph2_w[m], err_w[m]} !== {e.p1, e.p2, e.err}) begin
                    bad++;
                    $display("FAIL %s map=%0d actual ph1/ph2/err=%b%b%b expected=%b%b%b at %0t",
                             e.tag, m, ph1_w[m], ph2_w[m], err_w[m], e.p1, e.p2, e.err, $time);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 and R4/R5: reset then fixed waveform at one clock per step
        div_val = 20'd1; tbl_en = 1'b0; pat1_in = 4'b1111; pat2_in = 4'b0000;
        do_reset("R1");
        repeat (16) clk_step("R4/R5/R8");

        // R2: slower step, taken at the next step-0
        div_val = 20'd3;
        repeat (40) clk_step("R2/R8");

        // R3: zero divide acts as one
        div_val = 20'd0;
        repeat (24) clk_step("R3");

        // R6: table mode with a nested pattern
        div_val = 20'd2; tbl_en = 1'b1; pat1_in = 4'b0010; pat2_in = 4'b0111;
        repeat (40) clk_step("R6");

        // R7: a short glitch away from the boundary is ignored
        while (m_slot != 2'd1) clk_step("R7");
        div_val = 20'd7; tbl_en = 1'b0; pat1_in = 4'b1111; pat2_in = 4'b0000;
        repeat (2) clk_step("R7");
        div_val = 20'd2; tbl_en = 1'b1; pat1_in = 4'b0010; pat2_in = 4'b0111;
        repeat (30) clk_step("R7");

        // R9: broken table raises the flag at the boundary, fixed table clears it
        pat1_in = 4'b0001; pat2_in = 4'b0000;
        repeat (30) clk_step("R9");
        pat2_in = 4'b1111;
        repeat (24) clk_step("R9");

        // R1 again: reset captures table settings directly
        div_val = 20'd4; tbl_en = 1'b1; pat1_in = 4'b0100; pat2_in = 4'b1110;
        do_reset("R1");
        repeat (40) clk_step("R6");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule